// File: doc/BRIEF.md
# Carry-Compartment Bitwise Logic Unit

This unit produces bitwise XOR and bitwise AND of two N-bit operands, the AND-reduction of one operand, and a plain N-bit sum. No logic gate forms any of these results. A single binary adder of width 2N computes all of them. For the two bitwise functions, each operand bit sits in its own two-bit lane. The upper bit of every lane is held at zero, so a carry that leaves a lane's low bit stops in the lane's empty high bit. The lane's low sum bit is then the XOR of the two inputs, and its high sum bit is their AND. The per-lane bits are then collected into N-bit results.

For the reduction, the same adder runs without interleaving. It adds the constant one to the operand and keeps the carry out of bit N-1. That carry is set only when every operand bit is one. The plain sum also uses the adder without interleaving.

A two-bit function select chooses among the four results. The selected value is registered on the clock edge that samples a valid input. A valid flag marks the cycle in which the result appears. The width N must be at least 2.

Top module: `adder_logic_unit`

## Requirements
- R1: With `func` = 2'b00, `res` equals `opa ^ opb`. Bit i comes from adder sum position 2i, and the operands are spread so that bit i occupies even position 2i and every odd position is zero.
- R2: With `func` = 2'b01, `res` equals `opa & opb`. Bit i comes from the carry caught in odd sum position 2i+1.
- R3: With `func` = 2'b10, `res` bit 0 is 1 exactly when every bit of `opa` is 1, and all other bits of `res` are 0. `opb` has no effect on this result.
- R4: With `func` = 2'b11, `res` equals `(opa + opb)` modulo 2^N.
- R5: A valid input sampled on a clock edge makes `res_vld` high after that edge, with the matching result on `res`.
- R6: When `in_vld` is low at an edge, `res_vld` is low after that edge and `res` keeps its previous value.
- R7: A synchronous active-high `rst` clears `res` and `res_vld` on the next edge. A valid input presented in the same cycle as the reset is discarded.
- R8: Valid inputs on consecutive cycles give results on consecutive cycles, one for one, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands and function select are valid |
| func | input | 2 | 00 XOR, 01 AND, 10 AND-reduce of opa, 11 sum |
| opa | input | N | First operand |
| opb | input | N | Second operand |
| res | output | N | Registered result |
| res_vld | output | 1 | Result is valid this cycle |

## Verification
A reset and a valid input can arrive in the same cycle. The reset must win, and the input must leave no trace. The bench provokes this with an all-ones AND request presented during reset. It judges the outcome on the next cycle: `res` must read zero and `res_vld` must stay low. The bench also checks that the following valid input is handled normally. The exhaustive sweep streams operands back to back, so a new valid input always coincides with the previous result being on the port. Every cycle's result is compared against the native operators.

// File: rtl/adder_logic_unit.sv
module adder_logic_unit #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [1:0]   func,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic [N-1:0] res,
  output logic         res_vld
);
  localparam int W = 2 * N;

  logic [W-1:0] spread_a, spread_b;
  logic [W-1:0] add_x, add_y, sum;
  logic [N-1:0] lane_lo, lane_hi, nxt;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign spread_a[2*i]   = opa[i];
    assign spread_a[2*i+1] = 1'b0;
    assign spread_b[2*i]   = opb[i];
    assign spread_b[2*i+1] = 1'b0;
    assign lane_lo[i]      = sum[2*i];
    assign lane_hi[i]      = sum[2*i+1];
  end

  always_comb begin
    case (func)
      2'b10:   begin add_x = {{N{1'b0}}, opa}; add_y = W'(1);            end
      2'b11:   begin add_x = {{N{1'b0}}, opa}; add_y = {{N{1'b0}}, opb}; end
      default: begin add_x = spread_a;         add_y = spread_b;         end
    endcase
  end

  assign sum = add_x + add_y;

  always_comb begin
    case (func)
      2'b00:   nxt = lane_lo;
      2'b01:   nxt = lane_hi;
      2'b10:   nxt = N'(sum[N]);
      default: nxt = sum[N-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= nxt;
    end
  end
endmodule

module adder_logic_unit_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [1:0]   func,
  input logic [N-1:0] opa,
  input logic [N-1:0] opb,
  input logic [N-1:0] res,
  input logic         res_vld
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) assert_reset_clears_R7: assert (res == '0 && !res_vld);

  assert_xor_R1: assert property (@(posedge clk) disable iff (rst)
    in_vld && func == 2'b00 |=> res == $past(opa ^ opb));
  assert_and_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld && func == 2'b01 |=> res == $past(opa & opb));
  assert_reduce_R3: assert property (@(posedge clk) disable iff (rst)
    in_vld && func == 2'b10 |=> res == N'($past(&opa)));
  assert_sum_R4: assert property (@(posedge clk) disable iff (rst)
    in_vld && func == 2'b11 |=> res == $past(opa + opb));
  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
  assert_idle_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_vld && $stable(res));
endmodule

bind adder_logic_unit adder_logic_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .func(func),
  .opa(opa), .opb(opb), .res(res), .res_vld(res_vld)
);

// File: tb/adder_logic_unit_bench.sv
module adder_logic_unit_bench;
  localparam int N = 6;
  localparam logic [N-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [1:0] func = 2'b00;
  logic [N-1:0] opa = '0, opb = '0;
  logic [N-1:0] res;
  logic res_vld;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] exp_q;

  always #10 clk = ~clk;

  adder_logic_unit #(.N(N)) u_adder_logic_unit (
    .clk(clk), .rst(rst), .in_vld(in_vld), .func(func),
    .opa(opa), .opb(opb), .res(res), .res_vld(res_vld)
  );

  function automatic logic [N-1:0] model(logic [1:0] f, logic [N-1:0] a, logic [N-1:0] b);
    case (f)
      2'b00:   return a ^ b;
      2'b01:   return a & b;
      2'b10:   return (a == ONES) ? N'(1) : '0;
      default: return a + b;
    endcase
  endfunction

  function automatic string tag(logic [1:0] f);
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(logic [1:0] f, logic [N-1:0] a, logic [N-1:0] b);
    func = f; opa = a; opb = b; in_vld = 1'b1;
    @(negedge clk);
    check("R5", N'(res_vld), N'(1));
    check(tag(f), res, model(f, a, b));
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R7", res, '0);
    check("R7", N'(res_vld), N'(0));
    rst = 1'b0;

    // R8: every operand pair of every function, streamed back to back
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          step(2'(f), N'(a), N'(b));

    step(2'b10, ONES, '0);
    step(2'b10, ONES, ONES);
    step(2'b10, ONES - 1, ONES);

    step(2'b11, ONES, 6'h15);
    exp_q = res;
    in_vld = 1'b0; opa = '0; opb = ONES; func = 2'b01;
    @(negedge clk);
    check("R6", N'(res_vld), N'(0));
    check("R6", res, exp_q);
    @(negedge clk);
    check("R6", res, exp_q);

    // R7: reset and a valid request in the same cycle
    rst = 1'b1; in_vld = 1'b1; func = 2'b01; opa = ONES; opb = ONES;
    @(negedge clk);
    check("R7", res, '0);
    check("R7", N'(res_vld), N'(0));
    rst = 1'b0;
    step(2'b00, 6'h2A, 6'h0F);
    in_vld = 1'b0;
    @(negedge clk);
    check("R6", N'(res_vld), N'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule